// File: doc/BRIEF.md
# Scanning ADC Conversion Sequencer

This block sits between a processor bus and an external analog-to-digital converter. Software programs an ordered list of up to sixteen 5-bit channel numbers and a start condition. The block then steps the converter through the list one conversion at a time, using a request/done handshake. It stores each result in a data register and signals completion through a status flag, a level interrupt and a single-cycle DMA request pulse.

A sequence is started in one of two ways. Software can start it with a write to the second control register. Alternatively, one of sixteen hardware trigger lines can start it on a chosen edge. Each trigger line passes through its own two-flop synchroniser and edge detector before the select mux. After power-on, a start is held back until a programmable settling delay has expired, and it is then carried out. While a sequence is running, further start requests are dropped.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, every register reads 0, and `conv_req`, `irq` and `dma_req` are low.
- R2: The sequence list is packed as 5-bit channel fields, and the block depends on this layout:
  - Entries 1–6 are at bit offsets 0, 5, 10, 15, 20 and 25 of the register at 0x34.
  - Entries 7–12 are at the same offsets in the register at 0x30.
  - Entries 13–16 are at offsets 0, 5, 10 and 15 of the register at 0x2C.
  - Bits 23:20 of 0x2C hold the number of conversions minus one.
  - With scan enabled (bit 8 of 0x04), one start converts all those entries in list order.
- R3: With scan disabled, a start converts entry 1 only, whatever the length field holds.
- R4: A write to 0x08 with bit 30 set starts a sequence only when the start-mode field of that write (bits 29:28) is 0. With any other mode, the write starts nothing.
- R5: Bits 27:24 of 0x08 select one trigger line. Bits 29:28 select the start mode: 1 starts on a rising edge, 2 on a falling edge, 3 on both edges. Lines that are not selected have no effect.
- R6: A trigger edge that arrives while a sequence is in progress is dropped.
- R7: Bit 0 of 0x08 powers the converter. A start that arrives within the settling delay after power-on is held, and the sequence runs once the delay ends. Starts while power is off are discarded.
- R8: Each result is placed in the low bits of 0x4C and sets bit 1 of the status register at 0x00. A read of 0x4C clears status bit 1.
- R9: When bit 10 of 0x08 is 1, status bit 1 is set after every conversion. When it is 0, status bit 1 is set only after the last conversion of a sequence.
- R10: Status bit 4 is set when a sequence starts. Writing 0 to that bit clears it; writing 1 leaves it unchanged.
- R11: `irq` is high while status bit 1 is set and bit 5 of 0x04 is set.
- R12: With bit 8 of 0x08 set, `dma_req` pulses for one cycle per conversion.
  - With bit 9 set, the pulses continue for every sequence.
  - With bit 9 clear, pulses stop after the first sequence ends, and resume only after bit 8 has been cleared and set again.
- R13: `conv_req` is high for exactly one cycle per conversion, and the next request is not issued until `conv_done` has arrived.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading 0x4C clears the end flag) |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| conv_req | output | 1 | One-cycle request to the converter |
| conv_chan | output | 5 | Channel for the current conversion |
| conv_done | input | 1 | Converter result valid |
| conv_data | input | DATA_W | Converter result |
| hw_trig | input | 16 | Asynchronous hardware trigger lines |
| irq | output | 1 | End-of-conversion interrupt |
| dma_req | output | 1 | One-cycle DMA request per result |

## Verification
Each result, together with its end flag, interrupt level and DMA pulse, appears in the cycle after the clock edge at which `conv_done` is sampled high. A trigger edge takes three register stages to reach the start logic, and `conv_req` follows one cycle later. The bench drives every input at falling edges and samples at falling edges. The converter model answers two falling edges after it sees a request, and records the interrupt level one falling edge after raising `conv_done`. Starts are followed by settle windows that are longer than the worst-case latency for the programmed length, so a count or value is never read while still in transit.

// File: rtl/adcseq_pkg.sv
package adcseq_pkg;
    localparam int CH_W      = 5;
    localparam int SEQ_DEPTH = 16;
    localparam int LEN_W     = $clog2(SEQ_DEPTH);
    localparam int TRIG_N    = 16;
    localparam int SEL_W     = $clog2(TRIG_N);

    localparam logic [7:0] A_STATUS = 8'h00;
    localparam logic [7:0] A_CTRL1  = 8'h04;
    localparam logic [7:0] A_CTRL2  = 8'h08;
    localparam logic [7:0] A_SEQ_A  = 8'h2C;
    localparam logic [7:0] A_SEQ_B  = 8'h30;
    localparam logic [7:0] A_SEQ_C  = 8'h34;
    localparam logic [7:0] A_DATA   = 8'h4C;

    localparam int B_EOC   = 1;
    localparam int B_STRT  = 4;
    localparam int B_EOCIE = 5;
    localparam int B_SCAN  = 8;
    localparam int B_POWER = 0;
    localparam int B_DMA   = 8;
    localparam int B_DDS   = 9;
    localparam int B_EOCS  = 10;
    localparam int B_LEN   = 20;
    localparam int B_SEL   = 24;
    localparam int B_MODE  = 28;
    localparam int B_SWGO  = 30;

    typedef enum logic [1:0] {
        START_SW   = 2'd0,
        START_RISE = 2'd1,
        START_FALL = 2'd2,
        START_BOTH = 2'd3
    } start_mode_e;

    typedef struct packed {
        start_mode_e      mode;
        logic [SEL_W-1:0] sel;
        logic             eoc_each;
        logic             dma_cont;
        logic             dma_en;
        logic             power;
    } ctrl2_t;

    // Entry index counts from 0; entries 0..5 live in seq_c, 6..11 in seq_b, 12..15 in seq_a.
    function automatic logic [CH_W-1:0] seq_entry(input logic [31:0] ra, input logic [31:0] rb,
                                                  input logic [31:0] rc, input logic [LEN_W-1:0] idx);
        logic [31:0] w;
        int unsigned k;
        k = 32'(idx);
        if (k < 6)       w = rc >> (CH_W * k);
        else if (k < 12) w = rb >> (CH_W * (k - 6));
        else             w = ra >> (CH_W * (k - 12));
        return w[CH_W-1:0];
    endfunction
endpackage

// File: rtl/adcseq_trig.sv
module adcseq_trig
    import adcseq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [TRIG_N-1:0] trig_in,
    input  logic [SEL_W-1:0]  sel,
    input  start_mode_e       mode,
    output logic              fire
);
    logic [TRIG_N-1:0] rise;
    logic [TRIG_N-1:0] fall;

    generate
        for (genvar g = 0; g < TRIG_N; g++) begin : g_line
            logic s1, s2, prv;
            always_ff @(posedge clk) begin
                if (rst) begin
                    s1  <= 1'b0;
                    s2  <= 1'b0;
                    prv <= 1'b0;
                end else begin
                    s1  <= trig_in[g];
                    s2  <= s1;
                    prv <= s2;
                end
            end
            assign rise[g] = s2 & ~prv;
            assign fall[g] = ~s2 & prv;
        end
    endgenerate

    always_comb begin
        unique case (mode)
            START_RISE: fire = rise[sel];
            START_FALL: fire = fall[sel];
            START_BOTH: fire = rise[sel] | fall[sel];
            default:    fire = 1'b0;
        endcase
    end
endmodule

// File: rtl/adcseq_engine.sv
module adcseq_engine
    import adcseq_pkg::*;
#(
    parameter int STAB_CYCLES = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             power,
    input  logic             scan,
    input  logic [LEN_W-1:0] last_idx,
    input  logic [31:0]      seq_a,
    input  logic [31:0]      seq_b,
    input  logic [31:0]      seq_c,
    input  logic             sw_start,
    input  logic             hw_fire,
    input  logic             conv_done,
    output logic             conv_req,
    output logic [CH_W-1:0]  conv_chan,
    output logic             seq_go,
    output logic             conv_fin,
    output logic             seq_end
);
    localparam int STAB_W = $clog2(STAB_CYCLES + 1);

    typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} st_e;

    st_e              st;
    logic [LEN_W-1:0] idx;
    logic             power_q;
    logic             pend;
    logic [STAB_W-1:0] stab_cnt;
    logic             idle, ready, ask;

    assign idle      = (st == S_IDLE);
    assign ready     = power & power_q & (stab_cnt == '0);
    assign ask       = (sw_start | hw_fire) & idle;
    assign seq_go    = ready & idle & (pend | ask);
    assign conv_req  = (st == S_REQ);
    assign conv_chan = seq_entry(seq_a, seq_b, seq_c, idx);
    assign conv_fin  = (st == S_WAIT) & conv_done;
    assign seq_end   = conv_fin & (~scan | (idx == last_idx));

    always_ff @(posedge clk) begin
        if (rst) begin
            st       <= S_IDLE;
            idx      <= '0;
            power_q  <= 1'b0;
            pend     <= 1'b0;
            stab_cnt <= '0;
        end else begin
            power_q <= power;
            if (!power)                stab_cnt <= '0;
            else if (!power_q)         stab_cnt <= STAB_W'(STAB_CYCLES);
            else if (stab_cnt != '0)   stab_cnt <= stab_cnt - 1'b1;
            pend <= power & ~seq_go & (pend | ask);
            if (!power) begin
                st <= S_IDLE;
            end else begin
                unique case (st)
                    S_IDLE: if (seq_go) begin
                        st  <= S_REQ;
                        idx <= '0;
                    end
                    S_REQ:  st <= S_WAIT;
                    S_WAIT: if (conv_fin) begin
                        if (seq_end) st <= S_IDLE;
                        else begin
                            idx <= idx + 1'b1;
                            st  <= S_REQ;
                        end
                    end
                    default: st <= S_IDLE;
                endcase
            end
        end
    end

    // R13
    req_single_chk: assert property (@(posedge clk) disable iff (rst)
        conv_req |=> !conv_req);

    // R7
    stab_hold_chk: assert property (@(posedge clk) disable iff (rst)
        conv_req |-> (power_q && stab_cnt == '0));
endmodule

// File: rtl/adcseq_regs.sv
module adcseq_regs
    import adcseq_pkg::*;
#(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              conv_fin,
    input  logic              seq_end,
    input  logic              seq_go,
    input  logic [DATA_W-1:0] conv_data,
    output logic              scan_en,
    output ctrl2_t            c2,
    output logic [31:0]       seq_a,
    output logic [31:0]       seq_b,
    output logic [31:0]       seq_c,
    output logic              sw_start,
    output logic              irq,
    output logic              dma_req
);
    logic              eoc_ie, eoc, strt, dma_halt;
    logic [DATA_W-1:0] data_q;
    logic              wr_stat, wr_c1, wr_c2, rd_data;

    assign wr_stat  = bus_wr && bus_addr == A_STATUS;
    assign wr_c1    = bus_wr && bus_addr == A_CTRL1;
    assign wr_c2    = bus_wr && bus_addr == A_CTRL2;
    assign rd_data  = bus_rd && bus_addr == A_DATA;
    assign sw_start = wr_c2 && bus_wdata[B_SWGO] && bus_wdata[B_MODE +: 2] == 2'b00;
    assign irq      = eoc & eoc_ie;

    always_ff @(posedge clk) begin
        if (rst) begin
            scan_en  <= 1'b0;
            eoc_ie   <= 1'b0;
            eoc      <= 1'b0;
            strt     <= 1'b0;
            c2       <= '0;
            seq_a    <= '0;
            seq_b    <= '0;
            seq_c    <= '0;
            data_q   <= '0;
            dma_req  <= 1'b0;
            dma_halt <= 1'b0;
        end else begin
            if (wr_stat) begin
                eoc  <= eoc & bus_wdata[B_EOC];
                strt <= strt & bus_wdata[B_STRT];
            end
            if (wr_c1) begin
                scan_en <= bus_wdata[B_SCAN];
                eoc_ie  <= bus_wdata[B_EOCIE];
            end
            if (wr_c2) begin
                c2.mode     <= start_mode_e'(bus_wdata[B_MODE +: 2]);
                c2.sel      <= bus_wdata[B_SEL +: SEL_W];
                c2.eoc_each <= bus_wdata[B_EOCS];
                c2.dma_cont <= bus_wdata[B_DDS];
                c2.dma_en   <= bus_wdata[B_DMA];
                c2.power    <= bus_wdata[B_POWER];
            end
            if (bus_wr && bus_addr == A_SEQ_A) seq_a <= bus_wdata;
            if (bus_wr && bus_addr == A_SEQ_B) seq_b <= bus_wdata;
            if (bus_wr && bus_addr == A_SEQ_C) seq_c <= bus_wdata;
            if (rd_data) eoc <= 1'b0;
            if (conv_fin) data_q <= conv_data;
            if (conv_fin && (c2.eoc_each || seq_end)) eoc <= 1'b1;
            if (seq_go) strt <= 1'b1;
            dma_req <= conv_fin & c2.dma_en & ~dma_halt;
            if (!c2.dma_en)                 dma_halt <= 1'b0;
            else if (seq_end && !c2.dma_cont) dma_halt <= 1'b1;
        end
    end

    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            A_STATUS: begin
                bus_rdata[B_EOC]  = eoc;
                bus_rdata[B_STRT] = strt;
            end
            A_CTRL1: begin
                bus_rdata[B_SCAN]  = scan_en;
                bus_rdata[B_EOCIE] = eoc_ie;
            end
            A_CTRL2: begin
                bus_rdata[B_POWER]         = c2.power;
                bus_rdata[B_DMA]           = c2.dma_en;
                bus_rdata[B_DDS]           = c2.dma_cont;
                bus_rdata[B_EOCS]          = c2.eoc_each;
                bus_rdata[B_SEL +: SEL_W]  = c2.sel;
                bus_rdata[B_MODE +: 2]     = c2.mode;
            end
            A_SEQ_A: bus_rdata = seq_a;
            A_SEQ_B: bus_rdata = seq_b;
            A_SEQ_C: bus_rdata = seq_c;
            A_DATA:  bus_rdata = {{(32-DATA_W){1'b0}}, data_q};
            default: bus_rdata = '0;
        endcase
    end

    // R8
    rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rd_data && !conv_fin) |-> !eoc);

    // R10
    strt_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(wr_stat && !bus_wdata[B_STRT] && !seq_go) |-> !strt);

    // R12
    dma_gate_chk: assert property (@(posedge clk) disable iff (rst)
        dma_req |-> $past(c2.dma_en));

    // R9
    eoc_end_chk: assert property (@(posedge clk) disable iff (rst)
        ($rose(eoc) && !$past(c2.eoc_each)) |-> $past(seq_end));
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
    import adcseq_pkg::*;
#(
    parameter int DATA_W      = 12,
    parameter int STAB_CYCLES = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              conv_req,
    output logic [CH_W-1:0]   conv_chan,
    input  logic              conv_done,
    input  logic [DATA_W-1:0] conv_data,
    input  logic [TRIG_N-1:0] hw_trig,
    output logic              irq,
    output logic              dma_req
);
    ctrl2_t      c2;
    logic        scan_en, sw_start, hw_fire, seq_go, conv_fin, seq_end;
    logic [31:0] seq_a, seq_b, seq_c;

    adcseq_regs #(.DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst(rst),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .conv_fin(conv_fin), .seq_end(seq_end), .seq_go(seq_go),
        .conv_data(conv_data),
        .scan_en(scan_en), .c2(c2),
        .seq_a(seq_a), .seq_b(seq_b), .seq_c(seq_c),
        .sw_start(sw_start), .irq(irq), .dma_req(dma_req)
    );

    adcseq_trig u_trig (
        .clk(clk), .rst(rst), .trig_in(hw_trig),
        .sel(c2.sel), .mode(c2.mode), .fire(hw_fire)
    );

    adcseq_engine #(.STAB_CYCLES(STAB_CYCLES)) u_engine (
        .clk(clk), .rst(rst),
        .power(c2.power), .scan(scan_en),
        .last_idx(seq_a[B_LEN +: LEN_W]),
        .seq_a(seq_a), .seq_b(seq_b), .seq_c(seq_c),
        .sw_start(sw_start), .hw_fire(hw_fire), .conv_done(conv_done),
        .conv_req(conv_req), .conv_chan(conv_chan),
        .seq_go(seq_go), .conv_fin(conv_fin), .seq_end(seq_end)
    );
endmodule

// File: tb/test_adc_scan_seq.sv
module test_adc_scan_seq;
    localparam logic [7:0] AS = 8'h00, AC1 = 8'h04, AC2 = 8'h08;
    localparam logic [7:0] SQA = 8'h2C, SQB = 8'h30, SQC = 8'h34, AD = 8'h4C;
    localparam int PWR = 1, DMA = 1 << 8, DDS = 1 << 9, EOCS = 1 << 10, GO = 1 << 30;

    logic        clk = 0, rst = 1;
    logic        bus_wr = 0, bus_rd = 0;
    logic [7:0]  bus_addr = 0;
    logic [31:0] bus_wdata = 0, bus_rdata;
    logic        conv_req, conv_done = 0, irq, dma_req;
    logic [4:0]  conv_chan;
    logic [11:0] conv_data = 0;
    logic [15:0] hw_trig = 0;

    int n_chk = 0, n_bad = 0, nreq = 0, ndone = 0, dma_cnt = 0, dbl_req = 0;
    logic [4:0] chlog [1024];
    logic       irqlog [1024];
    bit         done_flag = 0;

    always #2 clk = ~clk;

    adc_scan_seq i_adc_scan_seq (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_req(conv_req),
        .conv_chan(conv_chan), .conv_done(conv_done), .conv_data(conv_data),
        .hw_trig(hw_trig), .irq(irq), .dma_req(dma_req)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input int d);
        @(negedge clk); bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic rd(input logic [7:0] a, output int v);
        @(negedge clk); bus_rd = 1; bus_addr = a; #1 v = bus_rdata;
        @(negedge clk); bus_rd = 0;
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // converter model: answers two falling edges after the request
    initial begin
        int pc = 0;
        logic [4:0] cur = 0;
        bit prev_req = 0;
        forever begin
            @(negedge clk);
            if (conv_done) begin conv_done = 0; irqlog[ndone] = irq; ndone++; end
            if (pc != 0) begin
                pc--;
                if (pc == 0) begin conv_done = 1; conv_data = {cur, 7'(ndone)}; end
            end
            if (conv_req && prev_req) dbl_req++;
            prev_req = conv_req;
            if (conv_req) begin chlog[nreq] = conv_chan; cur = conv_chan; nreq++; pc = 2; end
            if (dma_req) dma_cnt++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic logic [4:0] ch_of(input int i, input int l);
        return 5'((i * 7 + l) % 32);
    endfunction

    initial begin
        int v, base, qa, qb, qc, d0;
        repeat (3) @(negedge clk);
        rst = 0;
        // R1: reset state
        foreach (chlog[i]) chlog[i] = 0;
        begin
            logic [7:0] addrs [7] = '{AS, AC1, AC2, SQA, SQB, SQC, AD};
            foreach (addrs[i]) begin
                rd(addrs[i], v);
                check(v == 0, "R1 reg", v, 0);
            end
        end
        check(!irq && !dma_req && !conv_req, "R1 outputs", int'({irq, dma_req, conv_req}), 0);

        // R7: start during settling is held
        base = nreq;
        wr(AC2, PWR);
        wr(AC2, PWR | GO);
        settle(4);
        check(nreq == base, "R7 held", nreq - base, 0);
        settle(30);
        check(nreq == base + 1, "R7 honoured", nreq - base, 1);
        rd(AD, v);
        // R7: power off discards a start
        wr(AC2, 0);
        wr(AC2, GO);
        settle(30);
        check(nreq == base + 1, "R7 power off", nreq - base, 1);
        wr(AC2, PWR);
        settle(20);
        check(nreq == base + 1, "R7 no replay", nreq - base, 1);

        // R2: scan sweep of every length
        wr(AC1, 1 << 8);
        for (int l = 1; l <= 16; l++) begin
            qa = (l - 1) << 20; qb = 0; qc = 0;
            for (int i = 0; i < l; i++) begin
                if (i < 6)       qc |= int'(ch_of(i, l)) << (5 * i);
                else if (i < 12) qb |= int'(ch_of(i, l)) << (5 * (i - 6));
                else             qa |= int'(ch_of(i, l)) << (5 * (i - 12));
            end
            wr(SQA, qa); wr(SQB, qb); wr(SQC, qc);
            base = nreq;
            wr(AC2, PWR | GO);
            settle(l * 5 + 15);
            check(nreq - base == l, "R2 count", nreq - base, l);
            for (int i = 0; i < l; i++)
                check(chlog[base + i] == ch_of(i, l), "R2 order", int'(chlog[base + i]), int'(ch_of(i, l)));
            rd(AS, v);
            check(v[1] == 1, "R8 eoc set", v[1], 1);
            rd(AD, v);
            d0 = int'({ch_of(l - 1, l), 7'(base + l - 1)});
            check(v == d0, "R8 data", v, d0);
            rd(AS, v);
            check(v[1] == 0, "R8 eoc cleared", v[1], 0);
        end

        // R3: no scan, only entry 1 (length field = 15 from sweep)
        wr(AC1, 0);
        base = nreq;
        wr(AC2, PWR | GO);
        settle(30);
        check(nreq - base == 1, "R3 count", nreq - base, 1);
        check(chlog[base] == ch_of(0, 16), "R3 chan", int'(chlog[base]), int'(ch_of(0, 16)));
        rd(AD, v);

        // R4: software start ignored when mode is nonzero
        base = nreq;
        wr(AC2, PWR | (1 << 28) | GO);
        settle(30);
        check(nreq == base, "R4 mode blocks", nreq - base, 0);

        // R5: every select, rising mode, neighbour line has no effect
        for (int s = 0; s < 16; s++) begin
            int o;
            o = (s + 1) % 16;
            wr(AC2, PWR | (1 << 28) | (s << 24));
            base = nreq;
            hw_trig[o] = 1; settle(8); hw_trig[o] = 0; settle(8);
            check(nreq == base, "R5 other line", nreq - base, 0);
            hw_trig[s] = 1; settle(12); hw_trig[s] = 0; settle(12);
            check(nreq == base + 1, "R5 rising", nreq - base, 1);
        end
        // R5 falling
        wr(AC2, PWR | (2 << 28) | (3 << 24));
        base = nreq;
        hw_trig[3] = 1; settle(15);
        check(nreq == base, "R5 falling no rise", nreq - base, 0);
        hw_trig[3] = 0; settle(15);
        check(nreq == base + 1, "R5 falling", nreq - base, 1);
        // R5 both
        wr(AC2, PWR | (3 << 28) | (3 << 24));
        base = nreq;
        hw_trig[3] = 1; settle(15);
        check(nreq == base + 1, "R5 both rise", nreq - base, 1);
        hw_trig[3] = 0; settle(15);
        check(nreq == base + 2, "R5 both fall", nreq - base, 2);
        rd(AD, v);

        // R6: edges during a running sequence are dropped
        wr(AC1, 1 << 8);
        wr(SQA, 7 << 20);
        wr(AC2, PWR | (1 << 28) | (2 << 24));
        base = nreq;
        hw_trig[2] = 1; settle(10); hw_trig[2] = 0; settle(2);
        hw_trig[2] = 1; settle(4); hw_trig[2] = 0;
        settle(60);
        check(nreq - base == 8, "R6 dropped", nreq - base, 8);
        hw_trig[2] = 1; settle(6); hw_trig[2] = 0; settle(60);
        check(nreq - base == 16, "R6 rearmed", nreq - base, 16);
        rd(AD, v);

        // R10: start flag
        rd(AS, v);
        check(v[4] == 1, "R10 set", v[4], 1);
        wr(AS, 32'hFFFF_FFFF);
        rd(AS, v);
        check(v[4] == 1, "R10 write one keeps", v[4], 1);
        wr(AS, ~(1 << 4));
        rd(AS, v);
        check(v[4] == 0, "R10 write zero clears", v[4], 0);

        // R9 / R11: end flag granularity seen at irq, length 3
        wr(SQA, 2 << 20);
        wr(AC1, (1 << 8) | (1 << 5));
        base = ndone;
        wr(AC2, PWR | GO);
        settle(30);
        check(irqlog[base] == 0 && irqlog[base + 1] == 0 && irqlog[base + 2] == 1, "R9 end only",
              int'({irqlog[base], irqlog[base + 1], irqlog[base + 2]}), 1);
        rd(AD, v);
        check(irq == 0, "R11 irq drops", irq, 0);
        base = ndone;
        wr(AC2, PWR | EOCS | GO);
        settle(30);
        check(irqlog[base] == 1 && irqlog[base + 1] == 1 && irqlog[base + 2] == 1, "R9 each",
              int'({irqlog[base], irqlog[base + 1], irqlog[base + 2]}), 7);
        rd(AD, v);
        wr(AC1, 1 << 8);
        base = ndone;
        wr(AC2, PWR | EOCS | GO);
        settle(30);
        check(irqlog[base] == 0 && irqlog[base + 2] == 0, "R11 masked", int'(irqlog[base + 2]), 0);
        rd(AS, v);
        check(v[1] == 1, "R11 flag kept", v[1], 1);
        rd(AD, v);

        // R12: DMA pulses
        d0 = dma_cnt;
        wr(AC2, PWR | DMA | DDS | GO); settle(30);
        wr(AC2, PWR | DMA | DDS | GO); settle(30);
        check(dma_cnt - d0 == 6, "R12 continuous", dma_cnt - d0, 6);
        d0 = dma_cnt;
        wr(AC2, PWR | DMA | GO); settle(30);
        wr(AC2, PWR | DMA | GO); settle(30);
        check(dma_cnt - d0 == 3, "R12 one shot", dma_cnt - d0, 3);
        wr(AC2, PWR);
        d0 = dma_cnt;
        wr(AC2, PWR | DMA | GO); settle(30);
        check(dma_cnt - d0 == 3, "R12 rearm", dma_cnt - d0, 3);

        // R13: never two request cycles in a row, one request per result
        check(dbl_req == 0, "R13 single cycle", dbl_req, 0);
        check(nreq == ndone, "R13 req vs done", nreq, ndone);

        done_flag = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule